// File: doc/BRIEF.md
# Banked Register File Read/Write Port Arbiter

This block forms the arbitration stage that follows instruction issue in a superscalar core whose physical register file is split into interleaved banks. Each bank has one local read port for left operands, one for right operands, and a small number of local write ports. Every cycle the stage takes the group of issued instructions. It decides which source operands receive a bank read port and which destinations receive a bank write port. It then grants or kills each instruction so that no stall is ever needed.

Left and right operands are arbitrated by two separate arbiters working in parallel. An operand that the bypass network will supply does not compete for a port. Operands on the same side that name the same physical register share one local port. Each source register number is decoded into a one-hot word select in parallel with arbitration, and the arbitration result only steers the already-decoded selects onto the bank ports. Any instruction that survives the stage is guaranteed a free write port, so its writeback cannot conflict. All results leave through one register stage.

Top module: `bank_port_arbiter`

## Requirements
- R1: All outputs are registered. The decision for the inputs present at a rising clock edge appears after that edge. While the active-low reset is asserted, every output is zero.
- R2: A register number r lives in bank r mod NUM_BANKS (its low bits) at word r / NUM_BANKS (its high bits). An enabled bank read port shows a one-hot word select with bit (r / NUM_BANKS) set. A disabled port shows all zeros.
- R3: An operand that is invalid, or whose bypass bit is set, requests no read port. It enables no bank port, never raises its bus-valid bit, and never causes a kill.
- R4: The left and right sides are arbitrated independently. A left and a right operand on different registers in the same bank are both granted.
- R5: Requests on one side for the same physical register share one local port, and none of them is denied.
- R6: On one side of a bank, the register of the lowest-numbered requesting slot owns the port. A slot on that side asking for a different register in that bank is denied and killed.
- R7: At most WR_PORTS (2) surviving instructions write any bank. Writers are served in slot order, and a writer beyond the limit is killed.
- R8: An instruction killed by a read denial takes no write port, and later writers to that bank may use the port.
- R9: slot_grant = valid and not killed. slot_kill = valid and denied (a read or a write). An invalid slot shows neither. conflict is high exactly when some kill bit is set.
- R10: lbus_vld[i] (rbus_vld[i]) is high when slot i reads its left (right) operand from the register file and is granted. lbus_bank/rbus_bank always carry the bank of that slot's source register number.
- R11: Write port p of bank b is enabled for the (p+1)-th surviving writer of bank b in slot order, and wport_slot carries that slot's index. Disabled write ports show slot 0.
- R12: A bank read port enable and its word select follow the owning register even when its owning slot is killed for another reason.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | ISSUE_W | Issued instruction valid per slot |
| src_l_vld | input | ISSUE_W | Left source operand present |
| src_l_byp | input | ISSUE_W | Left operand comes from bypass |
| src_l_reg | input | ISSUE_W*REG_W | Left source register numbers, slot 0 in low bits |
| src_r_vld | input | ISSUE_W | Right source operand present |
| src_r_byp | input | ISSUE_W | Right operand comes from bypass |
| src_r_reg | input | ISSUE_W*REG_W | Right source register numbers |
| dst_wr | input | ISSUE_W | Instruction writes a destination |
| dst_reg | input | ISSUE_W*REG_W | Destination register numbers |
| slot_grant | output | ISSUE_W | Instruction passes arbitration |
| slot_kill | output | ISSUE_W | Instruction killed (kill mask) |
| conflict | output | 1 | Some slot was killed |
| lport_en | output | NUM_BANKS | Left local read port enable per bank |
| lport_word | output | NUM_BANKS*WORDS | One-hot word select per bank left port |
| rport_en | output | NUM_BANKS | Right local read port enable per bank |
| rport_word | output | NUM_BANKS*WORDS | One-hot word select per bank right port |
| lbus_vld | output | ISSUE_W | Global left bus i reads the register file |
| lbus_bank | output | ISSUE_W*BANK_W | Bank steering select for global left bus i |
| rbus_vld | output | ISSUE_W | Global right bus i reads the register file |
| rbus_bank | output | ISSUE_W*BANK_W | Bank steering select for global right bus i |
| wport_en | output | NUM_BANKS*WR_PORTS | Local write port enable, index b*WR_PORTS+p |
| wport_slot | output | NUM_BANKS*WR_PORTS*SLOT_W | Slot steered to each local write port |

## Verification
Several properties are checked on every cycle against the previous cycle's inputs. Every valid slot ends up either granted or killed, never both. No two granted slots read different registers on one side of a bank. No bank has more granted writers than write ports. A bypassed operand never raises a bus-valid bit. Each port's word select is one-hot exactly when the port is enabled. Which slot wins, the release of a write port by a read-killed slot, sharing of equal registers, and the exact write-port steering can only be shown by the bench. Its scenarios and reference model compare every output field each cycle.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  // default geometry: four-issue core, 64 physical registers, 8 banks
  localparam int unsigned DEF_ISSUE_W   = 4;
  localparam int unsigned DEF_NUM_REGS  = 64;
  localparam int unsigned DEF_NUM_BANKS = 8;
  localparam int unsigned DEF_WR_PORTS  = 2;
endpackage

// File: rtl/bpa_addr_dec.sv
// Splits a register number into bank index and a one-hot word select.
module bpa_addr_dec #(
  parameter int unsigned REG_W  = 6,
  parameter int unsigned BANK_W = 3,
  localparam int unsigned WORDS = 1 << (REG_W - BANK_W)
) (
  input  logic [REG_W-1:0]  reg_num,
  output logic [BANK_W-1:0] bank,
  output logic [WORDS-1:0]  word_sel
);
  always_comb begin
    bank     = reg_num[BANK_W-1:0];
    word_sel = '0;
    word_sel[reg_num[REG_W-1:BANK_W]] = 1'b1;
  end
endmodule

// File: rtl/bpa_side_arb.sv
// One side (left or right) of read port arbitration, fixed slot priority,
// with sharing of identical registers.
module bpa_side_arb #(
  parameter int unsigned N      = 4,
  parameter int unsigned NB     = 8,
  parameter int unsigned REG_W  = 6,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned WORDS  = 8
) (
  input  logic [N-1:0]        req,
  input  logic [N*REG_W-1:0]  regs,
  input  logic [N*BANK_W-1:0] banks,
  input  logic [N*WORDS-1:0]  wsel,
  output logic [N-1:0]        gnt,
  output logic [NB-1:0]       port_en,
  output logic [NB*WORDS-1:0] port_word
);
  logic [NB-1:0]    own_vld;
  logic [REG_W-1:0] own_reg [NB];

  always_comb begin
    own_vld   = '0;
    port_word = '0;
    gnt       = '0;
    for (int b = 0; b < int'(NB); b++) own_reg[b] = '0;
    for (int i = 0; i < int'(N); i++) begin
      int bi;
      bi = int'(banks[i*BANK_W +: BANK_W]);
      if (req[i] && !own_vld[bi]) begin
        own_vld[bi]                  = 1'b1;
        own_reg[bi]                  = regs[i*REG_W +: REG_W];
        port_word[bi*WORDS +: WORDS] = wsel[i*WORDS +: WORDS];
      end
    end
    for (int i = 0; i < int'(N); i++) begin
      int bi;
      bi = int'(banks[i*BANK_W +: BANK_W]);
      gnt[i] = req[i] && (own_reg[bi] == regs[i*REG_W +: REG_W]);
    end
    port_en = own_vld;
  end
endmodule

// File: rtl/bpa_wr_alloc.sv
// Allocates local write ports per bank in slot order.
module bpa_wr_alloc #(
  parameter int unsigned N      = 4,
  parameter int unsigned NB     = 8,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned WP     = 2,
  parameter int unsigned SLOT_W = 2
) (
  input  logic [N-1:0]           wreq,
  input  logic [N*BANK_W-1:0]    banks,
  output logic [N-1:0]           wgnt,
  output logic [NB*WP-1:0]       wport_en,
  output logic [NB*WP*SLOT_W-1:0] wport_slot
);
  int wr_cnt [NB];

  always_comb begin
    wgnt       = '0;
    wport_en   = '0;
    wport_slot = '0;
    for (int b = 0; b < int'(NB); b++) wr_cnt[b] = 0;
    for (int i = 0; i < int'(N); i++) begin
      int bi;
      int idx;
      bi  = int'(banks[i*BANK_W +: BANK_W]);
      idx = bi * int'(WP) + wr_cnt[bi];
      if (wreq[i] && (wr_cnt[bi] < int'(WP))) begin
        wgnt[i]                              = 1'b1;
        wport_en[idx]                        = 1'b1;
        wport_slot[idx*SLOT_W +: SLOT_W]     = SLOT_W'(i);
        wr_cnt[bi]                           = wr_cnt[bi] + 1;
      end
    end
  end
endmodule

// File: rtl/bank_port_arbiter.sv
module bank_port_arbiter
  import bpa_pkg::*;
#(
  parameter int unsigned ISSUE_W   = DEF_ISSUE_W,
  parameter int unsigned NUM_REGS  = DEF_NUM_REGS,
  parameter int unsigned NUM_BANKS = DEF_NUM_BANKS,
  parameter int unsigned WR_PORTS  = DEF_WR_PORTS,
  localparam int unsigned REG_W  = $clog2(NUM_REGS),
  localparam int unsigned BANK_W = $clog2(NUM_BANKS),
  localparam int unsigned WORDS  = NUM_REGS / NUM_BANKS,
  localparam int unsigned SLOT_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [ISSUE_W-1:0]                   slot_vld,
  input  logic [ISSUE_W-1:0]                   src_l_vld,
  input  logic [ISSUE_W-1:0]                   src_l_byp,
  input  logic [ISSUE_W*REG_W-1:0]             src_l_reg,
  input  logic [ISSUE_W-1:0]                   src_r_vld,
  input  logic [ISSUE_W-1:0]                   src_r_byp,
  input  logic [ISSUE_W*REG_W-1:0]             src_r_reg,
  input  logic [ISSUE_W-1:0]                   dst_wr,
  input  logic [ISSUE_W*REG_W-1:0]             dst_reg,
  output logic [ISSUE_W-1:0]                   slot_grant,
  output logic [ISSUE_W-1:0]                   slot_kill,
  output logic                                 conflict,
  output logic [NUM_BANKS-1:0]                 lport_en,
  output logic [NUM_BANKS*WORDS-1:0]           lport_word,
  output logic [NUM_BANKS-1:0]                 rport_en,
  output logic [NUM_BANKS*WORDS-1:0]           rport_word,
  output logic [ISSUE_W-1:0]                   lbus_vld,
  output logic [ISSUE_W*BANK_W-1:0]            lbus_bank,
  output logic [ISSUE_W-1:0]                   rbus_vld,
  output logic [ISSUE_W*BANK_W-1:0]            rbus_bank,
  output logic [NUM_BANKS*WR_PORTS-1:0]        wport_en,
  output logic [NUM_BANKS*WR_PORTS*SLOT_W-1:0] wport_slot
);
  // decoded operand fields, produced in parallel with arbitration
  logic [ISSUE_W*BANK_W-1:0] l_bank, r_bank, d_bank;
  logic [ISSUE_W*WORDS-1:0]  l_wsel, r_wsel;

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_dec
    bpa_addr_dec #(.REG_W(REG_W), .BANK_W(BANK_W)) u_ldec (
      .reg_num (src_l_reg[s*REG_W +: REG_W]),
      .bank    (l_bank[s*BANK_W +: BANK_W]),
      .word_sel(l_wsel[s*WORDS +: WORDS])
    );
    bpa_addr_dec #(.REG_W(REG_W), .BANK_W(BANK_W)) u_rdec (
      .reg_num (src_r_reg[s*REG_W +: REG_W]),
      .bank    (r_bank[s*BANK_W +: BANK_W]),
      .word_sel(r_wsel[s*WORDS +: WORDS])
    );
    assign d_bank[s*BANK_W +: BANK_W] = dst_reg[s*REG_W +: BANK_W];
  end

  logic [ISSUE_W-1:0] l_req, r_req, l_gnt, r_gnt, rd_ok, w_req, w_gnt;
  logic [ISSUE_W-1:0] kill_d, grant_d;
  logic [NUM_BANKS-1:0] lport_en_d, rport_en_d;
  logic [NUM_BANKS*WORDS-1:0] lport_word_d, rport_word_d;
  logic [NUM_BANKS*WR_PORTS-1:0] wport_en_d;
  logic [NUM_BANKS*WR_PORTS*SLOT_W-1:0] wport_slot_d;

  assign l_req = slot_vld & src_l_vld & ~src_l_byp;
  assign r_req = slot_vld & src_r_vld & ~src_r_byp;

  bpa_side_arb #(.N(ISSUE_W), .NB(NUM_BANKS), .REG_W(REG_W), .BANK_W(BANK_W),
                 .WORDS(WORDS)) u_left (
    .req(l_req), .regs(src_l_reg), .banks(l_bank), .wsel(l_wsel),
    .gnt(l_gnt), .port_en(lport_en_d), .port_word(lport_word_d)
  );
  bpa_side_arb #(.N(ISSUE_W), .NB(NUM_BANKS), .REG_W(REG_W), .BANK_W(BANK_W),
                 .WORDS(WORDS)) u_right (
    .req(r_req), .regs(src_r_reg), .banks(r_bank), .wsel(r_wsel),
    .gnt(r_gnt), .port_en(rport_en_d), .port_word(rport_word_d)
  );

  // a read-denied instruction never competes for a write port
  assign rd_ok = slot_vld & ~(l_req & ~l_gnt) & ~(r_req & ~r_gnt);
  assign w_req = rd_ok & dst_wr;

  bpa_wr_alloc #(.N(ISSUE_W), .NB(NUM_BANKS), .BANK_W(BANK_W), .WP(WR_PORTS),
                 .SLOT_W(SLOT_W)) u_wr (
    .wreq(w_req), .banks(d_bank), .wgnt(w_gnt),
    .wport_en(wport_en_d), .wport_slot(wport_slot_d)
  );

  assign kill_d  = slot_vld & ~(rd_ok & (~dst_wr | w_gnt));
  assign grant_d = slot_vld & ~kill_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_grant <= '0;
      slot_kill  <= '0;
      conflict   <= 1'b0;
      lport_en   <= '0;
      lport_word <= '0;
      rport_en   <= '0;
      rport_word <= '0;
      lbus_vld   <= '0;
      lbus_bank  <= '0;
      rbus_vld   <= '0;
      rbus_bank  <= '0;
      wport_en   <= '0;
      wport_slot <= '0;
    end else begin
      slot_grant <= grant_d;
      slot_kill  <= kill_d;
      conflict   <= |kill_d;
      lport_en   <= lport_en_d;
      lport_word <= lport_word_d;
      rport_en   <= rport_en_d;
      rport_word <= rport_word_d;
      lbus_vld   <= l_req & grant_d;
      lbus_bank  <= l_bank;
      rbus_vld   <= r_req & grant_d;
      rbus_bank  <= r_bank;
      wport_en   <= wport_en_d;
      wport_slot <= wport_slot_d;
    end
  end
endmodule

// File: rtl/bpa_checker.sv
module bpa_checker #(
  parameter int unsigned ISSUE_W   = 4,
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned WR_PORTS  = 2,
  parameter int unsigned REG_W     = 6,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned WORDS     = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [ISSUE_W-1:0]           slot_vld,
  input logic [ISSUE_W-1:0]           src_l_vld,
  input logic [ISSUE_W-1:0]           src_l_byp,
  input logic [ISSUE_W*REG_W-1:0]     src_l_reg,
  input logic [ISSUE_W-1:0]           src_r_vld,
  input logic [ISSUE_W-1:0]           src_r_byp,
  input logic [ISSUE_W*REG_W-1:0]     src_r_reg,
  input logic [ISSUE_W-1:0]           dst_wr,
  input logic [ISSUE_W*REG_W-1:0]     dst_reg,
  input logic [ISSUE_W-1:0]           slot_grant,
  input logic [ISSUE_W-1:0]           slot_kill,
  input logic                         conflict,
  input logic [NUM_BANKS-1:0]         lport_en,
  input logic [NUM_BANKS*WORDS-1:0]   lport_word,
  input logic [NUM_BANKS-1:0]         rport_en,
  input logic [NUM_BANKS*WORDS-1:0]   rport_word,
  input logic [ISSUE_W-1:0]           lbus_vld,
  input logic [ISSUE_W-1:0]           rbus_vld
);
  // copies of the inputs seen at the last edge
  logic                     q_ok;
  logic [ISSUE_W-1:0]       q_vld, q_lreq, q_rreq, q_wr;
  logic [ISSUE_W*REG_W-1:0] q_lreg, q_rreg, q_dreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ok <= 1'b0; q_vld <= '0; q_lreq <= '0; q_rreq <= '0; q_wr <= '0;
      q_lreg <= '0; q_rreg <= '0; q_dreg <= '0;
    end else begin
      q_ok   <= 1'b1;
      q_vld  <= slot_vld;
      q_lreq <= slot_vld & src_l_vld & ~src_l_byp;
      q_rreq <= slot_vld & src_r_vld & ~src_r_byp;
      q_wr   <= dst_wr;
      q_lreg <= src_l_reg;
      q_rreg <= src_r_reg;
      q_dreg <= dst_reg;
    end
  end

  logic l_clash, r_clash, wr_over;
  always_comb begin
    l_clash = 1'b0;
    r_clash = 1'b0;
    wr_over = 1'b0;
    for (int i = 0; i < int'(ISSUE_W); i++) begin
      for (int j = i + 1; j < int'(ISSUE_W); j++) begin
        if (slot_grant[i] && slot_grant[j] && q_lreq[i] && q_lreq[j] &&
            q_lreg[i*REG_W +: BANK_W] == q_lreg[j*REG_W +: BANK_W] &&
            q_lreg[i*REG_W +: REG_W] != q_lreg[j*REG_W +: REG_W])
          l_clash = 1'b1;
        if (slot_grant[i] && slot_grant[j] && q_rreq[i] && q_rreq[j] &&
            q_rreg[i*REG_W +: BANK_W] == q_rreg[j*REG_W +: BANK_W] &&
            q_rreg[i*REG_W +: REG_W] != q_rreg[j*REG_W +: REG_W])
          r_clash = 1'b1;
      end
    end
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      int n;
      n = 0;
      for (int i = 0; i < int'(ISSUE_W); i++)
        if (slot_grant[i] && q_wr[i] && int'(q_dreg[i*REG_W +: BANK_W]) == b) n++;
      if (n > int'(WR_PORTS)) wr_over = 1'b1;
    end
  end

  p_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_ok |-> (((slot_grant | slot_kill) == q_vld) && ((slot_grant & slot_kill) == '0)));
  p_conflict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conflict == (slot_kill != '0));
  p_read_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_ok |-> (!l_clash && !r_clash));
  p_write_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_ok |-> !wr_over);
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_ok |-> (((lbus_vld & ~q_lreq) == '0) && ((rbus_vld & ~q_rreq) == '0)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_port
    p_word_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lport_word[b*WORDS +: WORDS]) && $onehot0(rport_word[b*WORDS +: WORDS]) &&
      (lport_en[b] == (lport_word[b*WORDS +: WORDS] != '0)) &&
      (rport_en[b] == (rport_word[b*WORDS +: WORDS] != '0)));
  end
endmodule

bind bank_port_arbiter bpa_checker #(
  .ISSUE_W(ISSUE_W), .NUM_BANKS(NUM_BANKS), .WR_PORTS(WR_PORTS),
  .REG_W(REG_W), .BANK_W(BANK_W), .WORDS(WORDS)
) chk_i (.*);

// File: tb/bank_port_arbiter_tb.sv
module bank_port_arbiter_tb_top;
  localparam int N = 4, NB = 8, WP = 2, RW = 6, BW = 3, WD = 8, SW = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [N-1:0] vld, lv, lb, rv, rb, dw;
  logic [N*RW-1:0] lreg, rreg, dreg;
  logic [N-1:0] grant, kill, lbv, rbv;
  logic conf;
  logic [NB-1:0] len, ren;
  logic [NB*WD-1:0] lword, rword;
  logic [N*BW-1:0] lbb, rbb;
  logic [NB*WP-1:0] wen;
  logic [NB*WP*SW-1:0] wslot;

  bank_port_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .slot_vld(vld),
    .src_l_vld(lv), .src_l_byp(lb), .src_l_reg(lreg),
    .src_r_vld(rv), .src_r_byp(rb), .src_r_reg(rreg),
    .dst_wr(dw), .dst_reg(dreg),
    .slot_grant(grant), .slot_kill(kill), .conflict(conf),
    .lport_en(len), .lport_word(lword), .rport_en(ren), .rport_word(rword),
    .lbus_vld(lbv), .lbus_bank(lbb), .rbus_vld(rbv), .rbus_bank(rbb),
    .wport_en(wen), .wport_slot(wslot)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected values from the requirements
  logic [N-1:0] e_grant, e_kill, e_lbv, e_rbv;
  logic e_conf;
  logic [NB-1:0] e_len, e_ren;
  logic [NB*WD-1:0] e_lword, e_rword;
  logic [N*BW-1:0] e_lbb, e_rbb;
  logic [NB*WP-1:0] e_wen;
  logic [NB*WP*SW-1:0] e_wslot;

  function automatic int rg(logic [N*RW-1:0] v, int i);
    return int'(v[i*RW +: RW]);
  endfunction

  task automatic model();
    int lown[NB], rown[NB], wcnt[NB];
    bit lok[N], rok[N], rdok[N];
    e_len = '0; e_ren = '0; e_lword = '0; e_rword = '0;
    e_wen = '0; e_wslot = '0; e_grant = '0; e_kill = '0;
    e_lbv = '0; e_rbv = '0; e_lbb = '0; e_rbb = '0;
    for (int b = 0; b < NB; b++) begin lown[b] = -1; rown[b] = -1; wcnt[b] = 0; end
    for (int i = 0; i < N; i++) begin
      e_lbb[i*BW +: BW] = BW'(rg(lreg, i) % NB);
      e_rbb[i*BW +: BW] = BW'(rg(rreg, i) % NB);
      if (vld[i] && lv[i] && !lb[i] && lown[rg(lreg, i) % NB] < 0) lown[rg(lreg, i) % NB] = rg(lreg, i);
      if (vld[i] && rv[i] && !rb[i] && rown[rg(rreg, i) % NB] < 0) rown[rg(rreg, i) % NB] = rg(rreg, i);
    end
    for (int b = 0; b < NB; b++) begin
      if (lown[b] >= 0) begin e_len[b] = 1'b1; e_lword[b*WD + lown[b]/NB] = 1'b1; end
      if (rown[b] >= 0) begin e_ren[b] = 1'b1; e_rword[b*WD + rown[b]/NB] = 1'b1; end
    end
    for (int i = 0; i < N; i++) begin
      lok[i] = !(vld[i] && lv[i] && !lb[i]) || lown[rg(lreg, i) % NB] == rg(lreg, i);
      rok[i] = !(vld[i] && rv[i] && !rb[i]) || rown[rg(rreg, i) % NB] == rg(rreg, i);
      rdok[i] = vld[i] && lok[i] && rok[i];
      if (vld[i]) begin
        e_kill[i] = !rdok[i];
        if (rdok[i] && dw[i]) begin
          int b;
          b = rg(dreg, i) % NB;
          if (wcnt[b] < WP) begin
            e_wen[b*WP + wcnt[b]] = 1'b1;
            e_wslot[(b*WP + wcnt[b])*SW +: SW] = SW'(i);
            wcnt[b]++;
          end else e_kill[i] = 1'b1;
        end
        e_grant[i] = !e_kill[i];
      end
      e_lbv[i] = e_grant[i] && lv[i] && !lb[i];
      e_rbv[i] = e_grant[i] && rv[i] && !rb[i];
    end
    e_conf = |e_kill;
  endtask

  task automatic cmp_all();
    model();
    chk("R9", "slot_grant", 64'(grant), 64'(e_grant));
    chk("R9", "slot_kill", 64'(kill), 64'(e_kill));
    chk("R9", "conflict", 64'(conf), 64'(e_conf));
    chk("R12", "lport_en", 64'(len), 64'(e_len));
    chk("R2", "lport_word", 64'(lword), 64'(e_lword));
    chk("R12", "rport_en", 64'(ren), 64'(e_ren));
    chk("R2", "rport_word", 64'(rword), 64'(e_rword));
    chk("R10", "lbus", {32'(lbv), 32'(lbb)}, {32'(e_lbv), 32'(e_lbb)});
    chk("R10", "rbus", {32'(rbv), 32'(rbb)}, {32'(e_rbv), 32'(e_rbb)});
    chk("R11", "wport", {32'(wen), 32'(wslot)}, {32'(e_wen), 32'(e_wslot)});
  endtask

  // inputs held from this negedge; decision visible after the next posedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic clr();
    vld = '0; lv = '0; lb = '0; rv = '0; rb = '0; dw = '0;
    lreg = '0; rreg = '0; dreg = '0;
  endtask

  task automatic set_l(int i, int r, bit byp);
    vld[i] = 1'b1; lv[i] = 1'b1; lb[i] = byp; lreg[i*RW +: RW] = RW'(r);
  endtask
  task automatic set_r(int i, int r, bit byp);
    vld[i] = 1'b1; rv[i] = 1'b1; rb[i] = byp; rreg[i*RW +: RW] = RW'(r);
  endtask
  task automatic set_d(int i, int r);
    vld[i] = 1'b1; dw[i] = 1'b1; dreg[i*RW +: RW] = RW'(r);
  endtask

  initial begin
    #(10 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clr();
    // R1: reset holds outputs low even with a conflicting group present
    set_d(0, 5); set_d(1, 13); set_d(2, 21);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset kill/grant", {60'd0, kill}, 64'd0);
    chk("R1", "reset wport_en", 64'(wen), 64'd0);
    chk("R1", "reset conflict", 64'(conf), 64'd0);
    rst_n = 1'b1;
    clr();
    step();

    // R5 / R6: shared register on left; different register same bank killed
    clr(); set_l(0, 3, 0); set_l(1, 3, 0); set_l(2, 11, 0); set_l(3, 4, 0);
    step();
    chk("R5", "shared slot1 kill", 64'(kill[1]), 64'd0);
    chk("R6", "kill mask", 64'(kill), 64'b0100);

    // R4: same bank, opposite sides, different registers
    clr(); set_l(0, 3, 0); set_r(0, 11, 0); set_l(1, 19, 0);
    step();
    chk("R4", "kill mask", 64'(kill), 64'b0010);
    chk("R4", "r word bank3", 64'(rword[3*WD +: WD]), 64'h02);

    // R3: bypassed operand does not compete
    clr(); set_l(0, 3, 0); set_l(1, 11, 1); set_r(2, 7, 1);
    step();
    chk("R3", "kill mask", 64'(kill), 64'd0);
    chk("R3", "bus valids", {32'(lbv), 32'(rbv)}, {32'b0001, 32'b0000});
    chk("R3", "r port en", 64'(ren), 64'd0);

    // R7: four writers to one bank
    clr(); set_d(0, 5); set_d(1, 13); set_d(2, 21); set_d(3, 29);
    step();
    chk("R7", "kill mask", 64'(kill), 64'b1100);

    // R8: read-killed slot releases its write port
    clr(); set_l(0, 2, 0); set_l(1, 10, 0); set_d(1, 13); set_d(2, 5); set_d(3, 21);
    step();
    chk("R8", "kill mask", 64'(kill), 64'b0010);
    chk("R8", "bank5 ports", 64'(wen[5*WP +: WP]), 64'b11);

    // R12: owner killed by write denial still drives its port
    clr(); set_d(0, 1); set_d(1, 9); set_l(2, 12, 0); set_d(2, 17); set_l(3, 20, 0);
    step();
    chk("R12", "kill mask", 64'(kill), 64'b1100);
    chk("R12", "bank4 left word", 64'(lword[4*WD +: WD]), 64'h02);

    // R9: invalid slots
    clr(); lv = '1; rv = '1; dw = '1;
    step();
    chk("R9", "idle grant/kill/conf", {59'd0, conf, grant}, 64'd0);

    // randomised groups with many conflicts
    for (int k = 0; k < 600; k++) begin
      clr();
      for (int i = 0; i < N; i++) begin
        vld[i] = ($urandom_range(0, 7) != 0);
        lv[i] = $urandom_range(0, 1); lb[i] = ($urandom_range(0, 3) == 0);
        rv[i] = $urandom_range(0, 1); rb[i] = ($urandom_range(0, 3) == 0);
        dw[i] = $urandom_range(0, 1);
        lreg[i*RW +: RW] = RW'($urandom_range(0, 23));
        rreg[i*RW +: RW] = RW'($urandom_range(0, 23));
        dreg[i*RW +: RW] = ($urandom_range(0, 1) != 0) ? RW'($urandom_range(0, 7) * 8 + 6)
                                                       : RW'($urandom_range(0, 63));
      end
      step();
    end

    // reset mid-run clears outputs
    clr(); set_l(0, 3, 0); set_l(1, 11, 0);
    step();
    rst_n = 1'b0;
    #1;
    chk("R1", "async reset", {59'd0, conf, kill}, 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule